// File: doc/BRIEF.md
# Hypervisor-Aware Interrupt Selector

This block chooses which pending interrupt a hart with machine, hypervisor-supervisor, virtual-supervisor and virtual-user privilege levels should take next. It combines the pending and enable vectors, the machine-level and hypervisor-level delegation masks, the current privilege level, the virtualization flag and the two global interrupt-enable bits. The result is a take flag and the index of the chosen cause.

Each interrupt that is both pending and enabled goes to one of three enable domains. The machine delegation mask and the hypervisor delegation mask decide the domain. A domain is open according to the privilege level the hart is running at. The hypervisor-supervisor domain is always open while the hart runs virtualized, because that level outranks the virtual levels. The virtual-supervisor domain opens only when the hart is virtualized and the supervisor-level enable holds.

The three guest interrupts (bits 2, 6 and 10) can never be handled by the machine level. For these bits the machine delegation mask is taken as one, whatever the input says. Among the interrupts that qualify, the one with the lowest index wins. Both outputs are registered, so the answer appears one clock after the inputs are sampled.

Top module: `hv_irq_select`

## Requirements
- R1: While `rst` is high at a clock edge, `take_o` becomes 0 and `cause_o` becomes 0.
- R2: Only bit positions where both `pend_i` and `en_i` are 1 can be selected. A pending bit that is not enabled is never taken.
- R3: Interrupts not delegated by the effective machine mask are gated by the machine enable. This enable is true when `priv_i` is not 3 (M), or when `priv_i` is 3 and `mie_bit_i` is 1.
- R4: Interrupts delegated by the machine mask but not by `hdeleg_i` are gated by the hypervisor enable. This enable is true when `virt_i` is 1, or when the supervisor enable is true. The supervisor enable is true when `priv_i` is 0 (U), or when `priv_i` is 1 (S) and `sie_bit_i` is 1.
- R5: Interrupts delegated by both the machine mask and `hdeleg_i` are gated by the virtual enable. This enable is `virt_i` AND the supervisor enable.
- R6: Bits 2, 6 and 10 are treated as machine-delegated whatever the value of `mdeleg_i` at those positions. They are never gated by the machine enable.
- R7: When several interrupts qualify, `cause_o` is the lowest qualified index and `take_o` is 1.
- R8: When no interrupt qualifies, `take_o` is 0 and `cause_o` is 0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_IRQ | Pending interrupt vector |
| en_i | input | NUM_IRQ | Interrupt enable vector |
| mdeleg_i | input | NUM_IRQ | Machine-level delegation mask |
| hdeleg_i | input | NUM_IRQ | Hypervisor-level delegation mask |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Hart runs virtualized |
| mie_bit_i | input | 1 | Machine global interrupt enable |
| sie_bit_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | IDX_W | Selected interrupt index |

## Verification
The assertions check several properties on every cycle:
- a registered take always points at a bit that was pending and enabled one cycle earlier;
- an idle output carries cause zero;
- the virtual enable never holds without the hypervisor enable;
- no lower qualified bit is ever skipped;
- guest bits never pass through the machine domain.

Whether the right domain opens for each mix of privilege, virtualization and delegation needs the bench's directed corners and its random comparison against a reference model. The same is true of whether the hardwired guest delegation overrides the input mask.

// File: rtl/hv_irq_pkg.sv
package hv_irq_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef struct packed {
    logic m_on;
    logic hs_on;
    logic vs_on;
  } dom_en_t;
endpackage

// File: rtl/hv_irq_domain_en.sv
module hv_irq_domain_en
  import hv_irq_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       mie_bit_i,
  input  logic       sie_bit_i,
  output dom_en_t    dom_o
);
  logic s_level_on;
  priv_e p;

  always_comb begin
    p          = priv_e'(priv_i);
    dom_o.m_on = (p != PRIV_MACH) || mie_bit_i;
    s_level_on = (p == PRIV_USER) || ((p == PRIV_SUPER) && sie_bit_i);
    dom_o.hs_on = virt_i || s_level_on;
    dom_o.vs_on = virt_i && s_level_on;
  end

  // R5: the virtual domain can only be open when the hypervisor domain is
  always_comb begin
    assert_vs_needs_hs_R5: assert (!dom_o.vs_on || dom_o.hs_on);
  end
endmodule

// File: rtl/hv_irq_qualify.sv
module hv_irq_qualify
  import hv_irq_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] live_i,
  input  logic [NUM_IRQ-1:0] mdel_eff_i,
  input  logic [NUM_IRQ-1:0] hdel_i,
  input  logic [NUM_IRQ-1:0] guest_i,
  input  dom_en_t            dom_i,
  output logic [NUM_IRQ-1:0] qual_o
);
  genvar b;
  generate
    for (b = 0; b < NUM_IRQ; b++) begin : g_bit
      logic to_m, to_hs, to_vs;
      always_comb begin
        to_m  = !mdel_eff_i[b];
        to_hs = mdel_eff_i[b] && !hdel_i[b];
        to_vs = mdel_eff_i[b] && hdel_i[b];
        qual_o[b] = live_i[b] &&
                    ((to_m && dom_i.m_on) ||
                     (to_hs && dom_i.hs_on) ||
                     (to_vs && dom_i.vs_on));
      end
      // R6: a guest bit never qualifies through the machine domain
      always_comb begin
        assert_guest_not_m_R6: assert (!(guest_i[b] && to_m));
      end
    end
  endgenerate
endmodule

// File: rtl/hv_irq_lowest.sv
module hv_irq_lowest #(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] req_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  // R7: no request below the chosen index is left pending
  always_comb begin
    for (int j = 0; j < NUM_IRQ; j++) begin
      assert_lowest_wins_R7: assert (!(found_o && (j < int'(idx_o)) && req_i[j]));
    end
  end
endmodule

// File: rtl/hv_irq_select.sv
module hv_irq_select
  import hv_irq_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] mdeleg_i,
  input  logic [NUM_IRQ-1:0] hdeleg_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               mie_bit_i,
  input  logic               sie_bit_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   cause_o
);
  logic [NUM_IRQ-1:0] guest_mask;
  logic [NUM_IRQ-1:0] mdel_eff;
  logic [NUM_IRQ-1:0] live;
  logic [NUM_IRQ-1:0] qual;
  dom_en_t            dom;
  logic               found;
  logic [IDX_W-1:0]   idx;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_guest
      assign guest_mask[g] = (g == 2) || (g == 6) || (g == 10);
    end
  endgenerate

  assign mdel_eff = mdeleg_i | guest_mask;
  assign live     = pend_i & en_i;

  hv_irq_domain_en u_dom (
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .mie_bit_i (mie_bit_i),
    .sie_bit_i (sie_bit_i),
    .dom_o     (dom)
  );

  hv_irq_qualify #(.NUM_IRQ(NUM_IRQ)) u_qual (
    .live_i     (live),
    .mdel_eff_i (mdel_eff),
    .hdel_i     (hdeleg_i),
    .guest_i    (guest_mask),
    .dom_i      (dom),
    .qual_o     (qual)
  );

  hv_irq_lowest #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .req_i   (qual),
    .found_o (found),
    .idx_o   (idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o  <= 1'b0;
      cause_o <= '0;
    end else begin
      take_o  <= found;
      cause_o <= found ? idx : '0;
    end
  end

  // R2: a taken cause was pending and enabled in the sampled cycle
  assert_take_was_live_R2: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (($past(pend_i & en_i) >> cause_o) & 1) != 0);

  // R8: idle output carries cause zero
  assert_idle_cause_R8: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> cause_o == '0);
endmodule

// File: tb/hv_irq_select_test.sv
module hv_irq_select_test;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] pend, en, md, hd;
  logic [1:0] priv;
  logic virt, mie, sie;
  logic take;
  logic [IW-1:0] cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hv_irq_select #(.NUM_IRQ(N)) uut (
    .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .mdeleg_i(md),
    .hdeleg_i(hd), .priv_i(priv), .virt_i(virt), .mie_bit_i(mie),
    .sie_bit_i(sie), .take_o(take), .cause_o(cause)
  );

  function automatic logic [IW:0] ref_pick(
      input logic [N-1:0] p, e, mdl, hdl, input logic [1:0] pr,
      input logic v, mi, si);
    logic [N-1:0] mde, q;
    logic m_on, s_on, hs_on, vs_on;
    mde   = mdl | 16'h0444;
    m_on  = (pr != 2'd3) || mi;
    s_on  = (pr == 2'd0) || ((pr == 2'd1) && si);
    hs_on = v || s_on;
    vs_on = v && s_on;
    q = p & e & ((~mde & {N{m_on}}) | (mde & ~hdl & {N{hs_on}}) |
                 (mde & hdl & {N{vs_on}}));
    for (int i = 0; i < N; i++)
      if (q[i]) return {1'b1, IW'(i)};
    return '0;
  endfunction

  task automatic check(input string tag, input logic t, input logic [IW-1:0] c);
    checks++;
    if (take !== t || cause !== c) begin
      errors++;
      $display("FAIL %s take=%0b cause=%0d expected take=%0b cause=%0d",
               tag, take, cause, t, c);
    end
  endtask

  task automatic apply(input string tag, input logic [N-1:0] p, e, mdl, hdl,
                       input logic [1:0] pr, input logic v, mi, si);
    logic [IW:0] exp;
    @(negedge clk);
    pend = p; en = e; md = mdl; hd = hdl; priv = pr; virt = v; mie = mi; sie = si;
    exp = ref_pick(p, e, mdl, hdl, pr, v, mi, si);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp[IW], exp[IW-1:0]);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; pend = '1; en = '1; md = '0; hd = '0; priv = 2'd3; virt = 0; mie = 1; sie = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1 reset", 1'b0, '0);
    rst = 0;

    // R2: pending but disabled is ignored
    apply("R2 disabled", 16'h0081, 16'h0080, '0, '0, 2'd3, 0, 1, 0);
    check("R2 picks enabled bit 7", 1'b1, 4'd7);
    // R3: M level with mie clear blocks M-routed
    apply("R3 M masked", 16'h0008, 16'hFFFF, '0, '0, 2'd3, 0, 0, 0);
    apply("R3 S priv opens M", 16'h0008, 16'hFFFF, '0, '0, 2'd1, 0, 0, 0);
    // R4: HS-routed at S with sie clear blocked; virtualized forces open
    apply("R4 S blocked", 16'h0020, 16'hFFFF, 16'h0020, '0, 2'd1, 0, 1, 0);
    apply("R4 virt forces HS", 16'h0020, 16'hFFFF, 16'h0020, '0, 2'd1, 1, 1, 0);
    apply("R4 M priv blocks HS", 16'h0020, 16'hFFFF, 16'h0020, '0, 2'd3, 0, 1, 1);
    // R5: VS-routed needs virt and s enable
    apply("R5 nonvirt VS off", 16'h0040, 16'hFFFF, 16'h0040, 16'h0040, 2'd1, 0, 1, 1);
    apply("R5 virt S sie clear", 16'h0040, 16'hFFFF, 16'h0040, 16'h0040, 2'd1, 1, 1, 0);
    apply("R5 virt U open", 16'h0040, 16'hFFFF, 16'h0040, 16'h0040, 2'd0, 1, 0, 0);
    // R6: guest bit 2 with mdeleg clear is still HS-routed, so mie is irrelevant
    apply("R6 guest not M", 16'h0004, 16'hFFFF, '0, '0, 2'd3, 0, 1, 0);
    apply("R6 guest via HS", 16'h0400, 16'hFFFF, '0, '0, 2'd1, 1, 0, 0);
    // R7: lowest wins
    apply("R7 lowest", 16'hF0F0, 16'hFFFF, '0, '0, 2'd0, 0, 0, 0);
    check("R7 bit 4", 1'b1, 4'd4);
    apply("R7 top bit", 16'h8000, 16'hFFFF, '0, '0, 2'd0, 0, 0, 0);
    // R8: nothing qualifies
    apply("R8 idle", 16'h0000, 16'hFFFF, '0, '0, 2'd0, 0, 0, 0);
    check("R8 zero", 1'b0, '0);
    // R9: a changed input takes effect one edge later
    @(negedge clk);
    pend = 16'h0002; en = 16'hFFFF; md = '0; hd = '0; priv = 2'd0; virt = 0;
    #1; check("R9 before edge", 1'b0, '0);
    @(posedge clk); @(negedge clk);
    check("R9 after edge", 1'b1, 4'd1);

    for (int k = 0; k < 3000; k++) begin
      logic [1:0] pr;
      pr = 2'($urandom_range(0, 2));
      if (pr == 2'd2) pr = 2'd3;
      apply("R7 random", 16'($urandom), 16'($urandom), 16'($urandom),
            16'($urandom), pr, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule